// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. A falling edge on an asynchronous, active-low convert request starts a conversion. The busy flag then drops, and the sequencer runs one bit decision per bit, starting at the most significant bit. For each decision it presents a trial code to an abstract DAC and reads back a comparator verdict. The comparator itself and the analog front end live outside the block.

After the least significant decision and a short settling tail, the result moves from the working register into the output shift register, and busy returns high. A parallel copy of the code and a one-cycle done pulse are also provided. The copy into the shift register is withheld while an external serial clock is selected, that clock is high and select is asserted. In that case the old shift-register word survives and the new result is lost from the serial path.

A power-down input is also handled. Raising it while the convert request is held low launches a conversion. Leaving power-down requires the convert request to be high before power-down drops.

Top module: `sar_seq`

## Requirements
- R1: A falling edge of `conv_n_i` seen while idle starts a conversion and drives `busy_n_o` low, whatever the level of `cs_n_i`.
- R2: Falling edges of `conv_n_i` that arrive while `busy_n_o` is low are ignored: they neither lengthen nor restart the conversion, nor alter its result.
- R3: `busy_n_o` stays low for exactly BITS*CYC_PER_BIT + TAIL_CYC clock cycles per conversion (51 with the defaults 12, 4, 3).
- R4: While deciding, `trial_o` holds the bits decided so far with the bit under trial set. The first trial is 12'h800 (bit 11 only), each trial lasts CYC_PER_BIT cycles, and `trial_o` is zero while idle.
- R5: At the end of each trial, the bit under trial is cleared if `cmp_gt_i` (trial above input) is high and is kept set otherwise. With an ideal comparator the final code therefore equals the input code.
- R6: In the first cycle that `busy_n_o` is high again, `done_o` is high for exactly one cycle and `code_o` holds the new result. Unless R7 applies, `sreg_o` also holds the new result. `sreg_o` changes at no other time.
- R7: When `ext_clk_i`=1, `sclk_i`=1 and `cs_n_i`=0 at the end of a conversion, `sreg_o` keeps its previous value. `code_o` is still updated.
- R8: A rising edge of `pwrdn_i` while idle, with `conv_n_i` low, starts a conversion. A rising edge with `conv_n_i` high does not.
- R9: After reset, `busy_n_o`=1, `done_o`=0, `pd_o`=0, and `trial_o`, `code_o` and `sreg_o` are all zero.
- R10: `pd_o` rises after `pwrdn_i` rises. It falls only once `pwrdn_i` is low and `conv_n_i` is high. While `conv_n_i` stays low, a low `pwrdn_i` leaves `pd_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n_i | input | 1 | Asynchronous convert request, falling edge starts |
| pwrdn_i | input | 1 | Asynchronous power-down request |
| ext_clk_i | input | 1 | High selects external serial clock mode |
| sclk_i | input | 1 | Level of the external serial clock |
| cs_n_i | input | 1 | Active-low chip select |
| cmp_gt_i | input | 1 | Comparator verdict: trial code above input |
| trial_o | output | 12 | Trial code driven to the DAC |
| busy_n_o | output | 1 | Active-low busy flag |
| done_o | output | 1 | One-cycle pulse when a conversion ends |
| code_o | output | 12 | Result of the last conversion |
| sreg_o | output | 12 | Parallel image of the output shift register |
| pd_o | output | 1 | Power-down state |

## Verification
The assertions take for granted that `cmp_gt_i` is a settled function of `trial_o`, valid in the same cycle. They also assume the clock, select and mode inputs are quiet for the few synchroniser cycles around the end of a conversion, so that the skip decision and the checker see the same level. The bench models the comparator as a combinational compare of `trial_o` against a held input code. It changes mode and select only while idle, well before the next start. It also toggles the convert request mid-conversion only after busy has already fallen.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_TAIL = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int              W    = 1,
    parameter logic [W-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INIT;
            stab_q <= INIT;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/sar_tick.sv
module sar_tick #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] CLAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = (cnt_q == CLAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = en_i && (cnt_q == CLAST);
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int BITS = 12,
    parameter int IDXW = 4
) (
    input  logic            active_i,
    input  logic [BITS-1:0] work_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [BITS-1:0] trial_o
);
    for (genvar b = 0; b < BITS; b++) begin : g_bit
        assign trial_o[b] = active_i && (work_i[b] || (idx_i == IDXW'(b)));
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int BITS        = 12,
    parameter int CYC_PER_BIT = 4,
    parameter int TAIL_CYC    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            conv_n_i,
    input  logic            pwrdn_i,
    input  logic            ext_clk_i,
    input  logic            sclk_i,
    input  logic            cs_n_i,
    input  logic            cmp_gt_i,
    output logic [BITS-1:0] trial_o,
    output logic            busy_n_o,
    output logic            done_o,
    output logic [BITS-1:0] code_o,
    output logic [BITS-1:0] sreg_o,
    output logic            pd_o
);
    localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int TW   = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;
    localparam logic [TW-1:0]   TLAST = TW'(TAIL_CYC - 1);
    localparam logic [IDXW-1:0] ITOP  = IDXW'(BITS - 1);

    typedef struct packed {
        sar_state_e      st;
        logic [IDXW-1:0] idx;
        logic [BITS-1:0] work;
        logic [BITS-1:0] sreg;
        logic [BITS-1:0] code;
        logic [TW-1:0]   tcnt;
        logic            done;
        logic            pd;
        logic            conv_p;
        logic            pwr_p;
    } regs_t;

    regs_t r_d, r_q;

    // synchronised request lines: conv_n resets high, power-down low
    logic [1:0] req_s;
    logic [2:0] sio_s;
    logic       conv_s_w, pwr_s_w;
    logic       conv_fall_w, pwr_rise_w, start_w, hold_w;
    logic       bit_last_w;

    sar_sync #(.W(2), .INIT(2'b10)) req_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({conv_n_i, pwrdn_i}),
        .sync_o  (req_s)
    );

    sar_sync #(.W(3), .INIT(3'b001)) sio_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_clk_i, sclk_i, cs_n_i}),
        .sync_o  (sio_s)
    );

    assign conv_s_w    = req_s[1];
    assign pwr_s_w     = req_s[0];
    assign conv_fall_w = r_q.conv_p && !conv_s_w;
    assign pwr_rise_w  = !r_q.pwr_p && pwr_s_w;
    assign start_w     = (r_q.st == ST_IDLE) &&
                         (conv_fall_w || (pwr_rise_w && !conv_s_w));
    // external clock selected, clock high, select asserted
    assign hold_w      = sio_s[2] && sio_s[1] && !sio_s[0];

    sar_tick #(.CYC(CYC_PER_BIT)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_w),
        .en_i   (r_q.st == ST_CONV),
        .last_o (bit_last_w)
    );

    sar_trial #(.BITS(BITS), .IDXW(IDXW)) trial_i (
        .active_i (r_q.st == ST_CONV),
        .work_i   (r_q.work),
        .idx_i    (r_q.idx),
        .trial_o  (trial_o)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.conv_p = conv_s_w;
        r_d.pwr_p  = pwr_s_w;

        if (pwr_rise_w) begin
            r_d.pd = 1'b1;
        end else if (r_q.pd && !pwr_s_w && conv_s_w) begin
            r_d.pd = 1'b0;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (start_w) begin
                    r_d.st   = ST_CONV;
                    r_d.idx  = ITOP;
                    r_d.work = '0;
                end
            end
            ST_CONV: begin
                if (bit_last_w) begin
                    r_d.work[r_q.idx] = !cmp_gt_i;
                    if (r_q.idx == '0) begin
                        r_d.st   = ST_TAIL;
                        r_d.tcnt = '0;
                    end else begin
                        r_d.idx = r_q.idx - 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (r_q.tcnt == TLAST) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.code = r_q.work;
                    if (!hold_w) begin
                        r_d.sreg = r_q.work;
                    end
                end else begin
                    r_d.tcnt = r_q.tcnt + 1'b1;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.conv_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_n_o = (r_q.st == ST_IDLE);
    assign done_o   = r_q.done;
    assign code_o   = r_q.code;
    assign sreg_o   = r_q.sreg;
    assign pd_o     = r_q.pd;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int BITS        = 12,
    parameter int CYC_PER_BIT = 4,
    parameter int TAIL_CYC    = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_n_o,
    input logic            done_o,
    input logic [BITS-1:0] trial_o,
    input logic [BITS-1:0] code_o,
    input logic [BITS-1:0] sreg_o,
    input logic            hold_w,
    input logic            conv_fall_w
);
    localparam int unsigned DEC   = BITS * CYC_PER_BIT;
    localparam int unsigned TOTAL = DEC + TAIL_CYC;

    int unsigned low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         low_q <= 0;
        else if (!busy_n_o) low_q <= low_q + 1;
        else                low_q <= 0;
    end

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n_o && conv_fall_w) |=> !busy_n_o);

    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n_o && conv_fall_w && low_q + 1 < TOTAL) |=> !busy_n_o);

    p_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n_o) |-> (low_q == TOTAL));

    p_trial_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n_o && low_q < DEC) |-> (trial_o != '0));

    p_trial_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n_o |-> (trial_o == '0));

    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(busy_n_o));

    p_sreg_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(sreg_o));

    p_sreg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !$past(hold_w)) |-> (sreg_o == code_o));

    p_sreg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(hold_w)) |-> $stable(sreg_o));
endmodule

bind sar_seq sar_seq_chk #(
    .BITS        (BITS),
    .CYC_PER_BIT (CYC_PER_BIT),
    .TAIL_CYC    (TAIL_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_n_o    (busy_n_o),
    .done_o      (done_o),
    .trial_o     (trial_o),
    .code_o      (code_o),
    .sreg_o      (sreg_o),
    .hold_w      (hold_w),
    .conv_fall_w (conv_fall_w)
);

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BITS  = 12;
    localparam int CYC   = 4;
    localparam int TAIL  = 3;
    localparam int TOTAL = BITS * CYC + TAIL;
    localparam int NVEC  = 8;

    // {input code, cs_n, ext_clk, sclk}
    localparam logic [14:0] VEC [NVEC] = '{
        {12'hA5C, 1'b0, 1'b0, 1'b0},
        {12'h000, 1'b0, 1'b0, 1'b0},
        {12'hFFF, 1'b1, 1'b0, 1'b0},
        {12'h800, 1'b0, 1'b1, 1'b0},
        {12'h7FF, 1'b0, 1'b1, 1'b1},
        {12'h123, 1'b1, 1'b1, 1'b1},
        {12'h001, 1'b0, 1'b0, 1'b1},
        {12'h5A5, 1'b0, 1'b1, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            conv_n = 1'b1, pwrdn = 1'b0;
    logic            ext_clk = 1'b0, sclk = 1'b0, cs_n = 1'b0;
    logic            cmp_gt;
    logic [BITS-1:0] trial, code, sreg;
    logic            busy_n, done, pd;
    logic [BITS-1:0] vin = '0;
    logic [BITS-1:0] exp_sreg = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ideal comparator: trial above the held input
    assign cmp_gt = (trial > vin);

    sar_seq #(.BITS(BITS), .CYC_PER_BIT(CYC), .TAIL_CYC(TAIL)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_n_i  (conv_n),
        .pwrdn_i   (pwrdn),
        .ext_clk_i (ext_clk),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .cmp_gt_i  (cmp_gt),
        .trial_o   (trial),
        .busy_n_o  (busy_n),
        .done_o    (done),
        .code_o    (code),
        .sreg_o    (sreg),
        .pd_o      (pd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // waits for busy to fall, measures the low phase, checks the end
    task automatic run_conv(input logic [BITS-1:0] v, input bit pulse,
                            input bit glitch, input bit lose);
        int w = 0;
        int k = 0;
        vin = v;
        if (pulse) conv_n = 1'b0;
        @(negedge clk);
        while (busy_n && w < 40) begin
            w++;
            @(negedge clk);
        end
        chk("R1", "busy fell after start", int'(busy_n), 0);
        while (!busy_n && k < 1000) begin
            if (k == 0) chk("R4", "first trial", int'(trial), 12'h800);
            if (k == CYC)
                chk("R4", "second trial", int'(trial), int'({v[11], 1'b1, 10'b0}));
            if (pulse && k == 2) conv_n = 1'b1;
            if (glitch && k == 10) conv_n = 1'b0;
            if (glitch && k == 16) conv_n = 1'b1;
            if (glitch && k == 30) conv_n = 1'b0;
            if (glitch && k == 34) conv_n = 1'b1;
            k++;
            @(negedge clk);
        end
        chk("R3", "busy low cycles", k, TOTAL);
        chk("R6", "done pulse", int'(done), 1);
        chk("R5", "result code", int'(code), int'(v));
        if (!lose) exp_sreg = v;
        chk(lose ? "R7" : "R6", "shift register", int'(sreg), int'(exp_sreg));
        chk("R4", "idle trial", int'(trial), 0);
        @(negedge clk);
        chk("R6", "done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset busy_n", int'(busy_n), 1);
        chk("R9", "reset done", int'(done), 0);
        chk("R9", "reset pd", int'(pd), 0);
        chk("R9", "reset trial", int'(trial), 0);
        chk("R9", "reset code", int'(code), 0);
        chk("R9", "reset sreg", int'(sreg), 0);

        for (int i = 0; i < NVEC; i++) begin
            cs_n    = VEC[i][2];
            ext_clk = VEC[i][1];
            sclk    = VEC[i][0];
            repeat (4) @(negedge clk);
            run_conv(VEC[i][14:3], 1'b1, (i % 2) == 1,
                     VEC[i][1] && VEC[i][0] && !VEC[i][2]);
            repeat (3) @(negedge clk);
        end

        // R2: extra falling edges during a conversion, result intact
        cs_n = 1'b0; ext_clk = 1'b0; sclk = 1'b0;
        repeat (4) @(negedge clk);
        run_conv(12'h3C6, 1'b1, 1'b1, 1'b0);
        repeat (8) @(negedge clk);
        chk("R2", "no restart after glitch", int'(busy_n), 1);

        // R8: convert low, then power-down rising starts a conversion
        vin = 12'h9B1;
        conv_n = 1'b0;
        run_conv(12'h9B1, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        pwrdn = 1'b1;
        run_conv(12'h46E, 1'b0, 1'b0, 1'b0);
        chk("R10", "pd set", int'(pd), 1);
        pwrdn = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10", "pd held while convert low", int'(pd), 1);
        conv_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10", "pd cleared", int'(pd), 0);

        // R8: power-down rising with convert high does not start
        pwrdn = 1'b1;
        repeat (8) @(negedge clk);
        chk("R8", "no start with convert high", int'(busy_n), 1);
        chk("R10", "pd set again", int'(pd), 1);
        pwrdn = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10", "pd cleared again", int'(pd), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule